// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit channel of a packet DMA engine. Software builds a chain of four-word descriptors in memory, each naming one frame held in a single buffer, then writes the first descriptor's address into the channel's head register. The channel fetches each descriptor over a simple request/acknowledge memory master. It reads the frame's bytes from the buffer and presents them one byte per transfer on a valid/ready byte stream, with a last flag on the final byte. Frames under 60 bytes are extended with zero bytes.

After a frame has gone out, the channel writes the flags word back with the ownership bit cleared. It latches a raw completion status bit, which software clears by writing the finished descriptor's address into the completion register. The channel then follows the next pointer, or stops at a null pointer. A teardown request halts the channel at the next descriptor boundary and leaves a fixed marker in the completion register. A malformed descriptor stops the channel with a sticky error flag.

Top module: `tx_dma_channel`

## Requirements
- R1: Register word index 1 (head) accepts a descriptor address. At byte offsets +0, +4, +8 and +12 from that address the channel reads four words: next pointer, buffer pointer, (buffer offset << 16 | buffer length), and flags. The flags word holds start-of-frame in bit 31, end-of-frame in bit 30, ownership in bit 29, end-of-queue in bit 28 and frame length in bits 15:0.
- R2: The channel makes no memory access and emits no byte while bit 0 of register index 0 (control) is clear. Setting that bit starts the descriptor already in the head register.
- R3: Stream byte k of a frame comes from byte address buffer + offset + k, where byte address A is bits [8*(A mod 4) +: 8] of the word at A with its two low bits cleared. Valid, data and last hold steady while ready is low, and last is set on the frame's final byte only.
- R4: A frame whose length is below 60 goes out as exactly 60 bytes, and every byte past the frame length is zero.
- R5: After a frame's final byte, the channel writes the flags word back with bit 29 cleared and bit 28 set exactly when the next pointer is zero. It then moves to the next descriptor, or leaves the head register at 0 and stops.
- R6: Each completed frame sets bit 0 of register index 4 (status), and the irq output mirrors that bit.
- R7: A write to register index 2 (completion) clears status bit 0 only if the value written equals the address of the most recently completed descriptor. Any other value leaves the bit set.
- R8: When a frame completes in the same cycle that software writes a matching completion value, status bit 0 ends up set.
- R9: A descriptor whose ownership bit is clear is not sent. The channel clears the head register, raises no status and stops.
- R10: A descriptor with start-of-frame or end-of-frame clear, a zero frame length, or a buffer length different from the frame length sets sticky status bit 1 and sends nothing. No descriptor starts while bit 1 is set. Writing 1 to status bit 1 clears it, and the channel then resumes from the head register.
- R11: Any write to register index 3 requests a teardown. It takes effect at a descriptor boundary, so a frame in flight is finished first. Teardown clears the head register, writes 0xFFFFFFFC into the completion register and sets status bit 0, which writing 0xFFFFFFFC to the completion register clears.
- R12: A write to the head register while the channel is working on a descriptor is ignored.
- R13: Once raised, a memory request keeps its address, direction and write data until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Raw completion status |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |

## Verification
The risky overlap is the channel setting the completion status in the same cycle that software clears it with the previous descriptor's address. The bench's memory model provokes this by injecting a completion-register write at the exact handshake of the second descriptor's write-back. The pass condition is that status bit 0 stays set and clears only once the newer address is written. A second overlap puts a teardown request and an ignored head write in the middle of a frame, and the bench expects the frame to finish intact before the teardown marker appears.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;
    localparam int WORD_W   = 32;
    localparam int LEN_W    = 16;
    localparam int WORD_B   = WORD_W / 8;
    localparam int LANE_W   = $clog2(WORD_B);
    localparam int BIT_SOP  = 31;
    localparam int BIT_EOP  = 30;
    localparam int BIT_OWN  = 29;
    localparam int BIT_EOQ  = 28;
    localparam logic [WORD_W-1:0] TD_MARK = 32'hFFFF_FFFC;

    typedef enum logic [2:0] {
        RG_CTRL  = 3'd0,
        RG_HEAD  = 3'd1,
        RG_COMP  = 3'd2,
        RG_TDOWN = 3'd3,
        RG_STAT  = 3'd4
    } reg_idx_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_STREAM,
        ST_WBACK
    } eng_state_e;

    typedef struct packed {
        eng_state_e        state;
        logic [1:0]        widx;
        logic [WORD_W-1:0] cur;
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] bufp;
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] word;
        logic [LEN_W-1:0]  off;
        logic [LEN_W-1:0]  blen;
        logic [LEN_W-1:0]  cnt;
        logic              have;
    } eng_s;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] head;
        logic [WORD_W-1:0] comp;
        logic [WORD_W-1:0] last;
        logic              done;
        logic              err;
        logic              td;
    } regs_s;
endpackage

// File: rtl/tx_dma_lane.sv
module tx_dma_lane #(
    parameter int BYTES = 4,
    localparam int SEL_W = $clog2(BYTES)
) (
    input  logic [8*BYTES-1:0] word_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [7:0]         byte_o
);
    logic [7:0] lanes [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lanes[g] = word_i[8*g +: 8];
    end

    assign byte_o = lanes[sel_i];
endmodule

// File: rtl/tx_dma_regs.sv
module tx_dma_regs
    import tx_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              eng_idle,
    input  logic              fin,
    input  logic [WORD_W-1:0] fin_addr,
    input  logic              td_ack,
    input  logic              err_set,
    input  logic              hd_upd,
    input  logic [WORD_W-1:0] hd_val,
    output logic              en,
    output logic [WORD_W-1:0] head,
    output logic              err,
    output logic              td_req
);
    regs_s q, d;

    logic wr_ctrl, wr_head, wr_comp, wr_td, wr_stat;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == RG_CTRL);
        wr_head = reg_wr && (reg_addr == RG_HEAD);
        wr_comp = reg_wr && (reg_addr == RG_COMP);
        wr_td   = reg_wr && (reg_addr == RG_TDOWN);
        wr_stat = reg_wr && (reg_addr == RG_STAT);

        d = q;
        if (wr_ctrl) d.en = reg_wdata[0];
        // head is software-writable only while the engine rests
        if (wr_head && eng_idle) d.head = reg_wdata;
        if (hd_upd) d.head = hd_val;

        if (wr_comp) d.comp = reg_wdata;
        if (td_ack) d.comp = TD_MARK;

        // acknowledge first, completion second: a new completion wins
        if (wr_comp && (reg_wdata == q.last)) d.done = 1'b0;
        if (fin) begin
            d.done = 1'b1;
            d.last = fin_addr;
        end

        if (wr_stat && reg_wdata[1]) d.err = 1'b0;
        if (err_set) d.err = 1'b1;

        if (wr_td) d.td = 1'b1;
        else if (td_ack) d.td = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RG_CTRL:  reg_rdata = {{(WORD_W-1){1'b0}}, q.en};
            RG_HEAD:  reg_rdata = q.head;
            RG_COMP:  reg_rdata = q.comp;
            RG_TDOWN: reg_rdata = {{(WORD_W-1){1'b0}}, q.td};
            RG_STAT:  reg_rdata = {{(WORD_W-2){1'b0}}, q.err, q.done};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq    = q.done;
    assign en     = q.en;
    assign head   = q.head;
    assign err    = q.err;
    assign td_req = q.td;

    AST_DONE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> q.done); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !(wr_stat && reg_wdata[1])) |=> q.err); // R10
    AST_HEAD_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_idle && !hd_upd) |=> $stable(q.head)); // R12
    AST_TD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        td_ack |=> (q.comp == TD_MARK) && (q.head == '0)); // R11
endmodule

// File: rtl/tx_dma_engine.sv
module tx_dma_engine
    import tx_dma_pkg::*;
#(
    parameter int MIN_LEN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [WORD_W-1:0] head,
    input  logic              err_in,
    input  logic              td_req,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              fin,
    output logic [WORD_W-1:0] fin_addr,
    output logic              td_ack,
    output logic              err_set,
    output logic              hd_upd,
    output logic [WORD_W-1:0] hd_val
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [WORD_W-1:0] FLAGS_OFS = WORD_W'(3 * WORD_B);

    eng_s q, d;

    logic [LEN_W-1:0]  pkt_len, total;
    logic              pad, at_last, lane_end;
    logic [WORD_W-1:0] byte_addr;
    logic [7:0]        lane_byte;

    assign pkt_len   = q.flags[LEN_W-1:0];
    assign total     = (pkt_len < MIN_L) ? MIN_L : pkt_len;
    assign pad       = q.cnt >= pkt_len;
    assign at_last   = q.cnt == (total - LEN_W'(1));
    assign byte_addr = q.bufp + WORD_W'(q.off) + WORD_W'(q.cnt);
    assign lane_end  = byte_addr[LANE_W-1:0] == {LANE_W{1'b1}};

    tx_dma_lane #(.BYTES(WORD_B)) u_lane (
        .word_i (q.word),
        .sel_i  (byte_addr[LANE_W-1:0]),
        .byte_o (lane_byte)
    );

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_data   = '0;
        tx_last   = 1'b0;
        fin       = 1'b0;
        fin_addr  = '0;
        td_ack    = 1'b0;
        err_set   = 1'b0;
        hd_upd    = 1'b0;
        hd_val    = '0;

        case (q.state)
            ST_IDLE: begin
                if (td_req) begin
                    td_ack   = 1'b1;
                    fin      = 1'b1;
                    fin_addr = TD_MARK;
                    hd_upd   = 1'b1;
                end else if (en && (head != '0) && !err_in) begin
                    d.state = ST_FETCH;
                    d.cur   = head;
                    d.widx  = '0;
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + WORD_W'({q.widx, {LANE_W{1'b0}}});
                if (mem_ack) begin
                    case (q.widx)
                        2'd0:    d.nxt  = mem_rdata;
                        2'd1:    d.bufp = mem_rdata;
                        2'd2:    {d.off, d.blen} = mem_rdata;
                        default: d.flags = mem_rdata;
                    endcase
                    if (q.widx == 2'd3) d.state = ST_CHECK;
                    else                d.widx  = q.widx + 2'd1;
                end
            end
            ST_CHECK: begin
                if (!q.flags[BIT_OWN]) begin
                    hd_upd  = 1'b1;
                    d.state = ST_IDLE;
                end else if (!q.flags[BIT_SOP] || !q.flags[BIT_EOP] ||
                             (pkt_len == '0) || (q.blen != pkt_len)) begin
                    err_set = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.state = ST_STREAM;
                    d.cnt   = '0;
                    d.have  = 1'b0;
                end
            end
            ST_STREAM: begin
                if (!pad && !q.have) begin
                    mem_req  = 1'b1;
                    mem_addr = {byte_addr[WORD_W-1:LANE_W], {LANE_W{1'b0}}};
                    if (mem_ack) begin
                        d.have = 1'b1;
                        d.word = mem_rdata;
                    end
                end else begin
                    tx_valid = 1'b1;
                    tx_data  = pad ? 8'h00 : lane_byte;
                    tx_last  = at_last;
                    if (tx_ready) begin
                        d.cnt = q.cnt + LEN_W'(1);
                        if (!pad && lane_end) d.have = 1'b0;
                        if (at_last) d.state = ST_WBACK;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur + FLAGS_OFS;
                mem_wdata = q.flags;
                mem_wdata[BIT_OWN] = 1'b0;
                mem_wdata[BIT_EOQ] = (q.nxt == '0);
                if (mem_ack) begin
                    fin      = 1'b1;
                    fin_addr = q.cur;
                    hd_upd   = 1'b1;
                    hd_val   = q.nxt;
                    d.state  = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle = (q.state == ST_IDLE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) &&
                                  $stable(mem_we) && $stable(mem_wdata)); // R13
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R3
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && (q.cnt >= pkt_len)) |-> (tx_data == 8'h00)); // R4
    AST_MIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |-> (q.cnt >= MIN_L - LEN_W'(1))); // R4
    AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[BIT_OWN]); // R5
    AST_NO_RUN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !en) |=> !mem_req && !tx_valid); // R2
endmodule

// File: rtl/tx_dma_channel.sv
module tx_dma_channel
    import tx_dma_pkg::*;
#(
    parameter int MIN_LEN = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last
);
    logic              eng_idle, fin, td_ack, err_set, hd_upd;
    logic [WORD_W-1:0] fin_addr, hd_val, head;
    logic              en, err, td_req;

    tx_dma_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .eng_idle  (eng_idle),
        .fin       (fin),
        .fin_addr  (fin_addr),
        .td_ack    (td_ack),
        .err_set   (err_set),
        .hd_upd    (hd_upd),
        .hd_val    (hd_val),
        .en        (en),
        .head      (head),
        .err       (err),
        .td_req    (td_req)
    );

    tx_dma_engine #(.MIN_LEN(MIN_LEN)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .head      (head),
        .err_in    (err),
        .td_req    (td_req),
        .idle      (eng_idle),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .fin       (fin),
        .fin_addr  (fin_addr),
        .td_ack    (td_ack),
        .err_set   (err_set),
        .hd_upd    (hd_upd),
        .hd_val    (hd_val)
    );
endmodule

// File: tb/sim_tx_dma_channel.sv
module sim_tx_dma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq, mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        tx_valid, tx_ready = 1'b1, tx_last;
    logic [7:0]  tx_data;

    logic        tb_wr = 1'b0;
    logic [2:0]  tb_addr = '0;
    logic [31:0] tb_data = '0;
    logic        col_wr = 1'b0, col_arm = 1'b0, col_hit = 1'b0;
    int          col_at = 0;
    logic [31:0] col_addr = '0;

    logic [31:0] mem [0:1023];
    logic [7:0]  cap [0:511];
    logic        capl [0:511];
    int cap_n = 0, last_cnt = 0, mem_seen = 0, wr_seen = 0, hold_viol = 0;
    int cyc = 0, checks = 0, fails = 0;
    logic bp_on = 1'b0, wd_hit = 1'b0, pend = 1'b0;
    logic [31:0] pend_addr = '0;

    localparam logic [31:0] MARK = 32'hFFFF_FFFC;

    always #5 clk = ~clk;

    assign reg_wr    = tb_wr | col_wr;
    assign reg_addr  = col_wr ? 3'd2 : tb_addr;
    assign reg_wdata = col_wr ? col_addr : tb_data;

    tx_dma_channel u0 (.*);

    // memory model: acknowledges on the second cycle a request is seen
    always @(negedge clk) begin
        col_wr = 1'b0;
        if (!rst_n) begin
            mem_ack = 1'b0;
            pend = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (!pend) begin
                pend = 1'b1;
                pend_addr = mem_addr;
            end else begin
                if (mem_addr != pend_addr) hold_viol++;
                pend = 1'b0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[11:2]] = mem_wdata;
                    wr_seen++;
                    if (col_arm && wr_seen == col_at) begin
                        col_wr = 1'b1;
                        col_hit = 1'b1;
                        col_arm = 1'b0;
                    end
                end else begin
                    mem_rdata = mem[mem_addr[11:2]];
                end
            end
        end else if (pend) begin
            hold_viol++;
            pend = 1'b0;
        end
    end

    // stream sink, monitors and watchdog
    always @(negedge clk) begin
        cyc++;
        tx_ready = !bp_on || (cyc % 3 != 0);
        if (rst_n && tx_valid && tx_ready) begin
            if (cap_n < 512) begin
                cap[cap_n]  = tx_data;
                capl[cap_n] = tx_last;
            end
            cap_n++;
            if (tx_last) last_cnt++;
        end
        if (mem_req) mem_seen++;
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        tb_wr = 1'b1; tb_addr = a; tb_data = v;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        tb_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [7:0] getb(input logic [31:0] a);
        return mem[a[11:2]][8*a[1:0] +: 8];
    endfunction

    function automatic logic [31:0] mkf(input bit sop, input bit eop, input bit own,
                                        input logic [15:0] len);
        return {sop, eop, own, 13'b0, len};
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt,
                            input logic [31:0] bufp, input logic [15:0] off,
                            input logic [15:0] blen, input logic [31:0] flags);
        mem[a[11:2]]       = nxt;
        mem[a[11:2] + 1]   = bufp;
        mem[a[11:2] + 2]   = {off, blen};
        mem[a[11:2] + 3]   = flags;
    endtask

    task automatic fill(input logic [31:0] a, input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            logic [31:0] b;
            b = a + k;
            mem[b[11:2]][8*b[1:0] +: 8] = 8'(seed * 3 + k * 5 + 1);
        end
    endtask

    task automatic clr_cap();
        cap_n = 0;
        last_cnt = 0;
    endtask

    // compares one captured frame against buffer bytes plus zero padding
    task automatic check_frame(input string req, input int base, input logic [31:0] src,
                               input int len);
        int total, bad, badk;
        logic [7:0] e;
        total = (len < 60) ? 60 : len;
        bad = 0;
        badk = -1;
        for (int k = 0; k < total; k++) begin
            e = (k < len) ? getb(src + k) : 8'h00;
            if (base + k >= cap_n || cap[base + k] !== e ||
                capl[base + k] !== (k == total - 1)) begin
                bad++;
                if (badk < 0) badk = k;
            end
        end
        check(bad == 0, req, 32'(badk), 32'(-1));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd_reg(3'(a), v);
            chk("R6 reset register value", v, 0);
        end
        check(!tx_valid && !mem_req && !irq, "R2 reset outputs idle",
              {29'b0, tx_valid, mem_req, irq}, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        fill(32'h400, 64, 1);
        put_desc(32'h100, 0, 32'h400, 0, 64, mkf(1, 1, 1, 64));
        clr_cap();
        mem_seen = 0;
        wr_reg(3'd1, 32'h100);
        wait_cyc(40);
        chk("R2 no memory access while disabled", 32'(mem_seen), 0);
        chk("R2 no bytes while disabled", 32'(cap_n), 0);
        wr_reg(3'd0, 1);
        wait_cyc(600);
        chk("R1 byte count of started frame", 32'(cap_n), 64);
        check_frame("R3 frame bytes and last flag", 0, 32'h400, 64);
        chk("R5 write-back flags of final descriptor", mem[32'h10C >> 2],
            mkf(1, 1, 0, 64) | 32'h1000_0000);
        rd_reg(3'd1, v);
        chk("R5 head cleared at end of chain", v, 0);
        rd_reg(3'd4, v);
        chk("R6 completion status set", v, 1);
        chk("R6 irq mirrors status", 32'(irq), 1);
        wr_reg(3'd2, 32'h100);
        rd_reg(3'd4, v);
        chk("R7 matching acknowledge clears status", v, 0);
    endtask

    task automatic t_short_pad();
        logic [31:0] v;
        fill(32'h503, 10, 7);
        put_desc(32'h110, 0, 32'h500, 3, 10, mkf(1, 1, 1, 10));
        clr_cap();
        bp_on = 1'b1;
        wr_reg(3'd1, 32'h110);
        wait_cyc(600);
        bp_on = 1'b0;
        chk("R4 short frame sent as 60 bytes", 32'(cap_n), 60);
        check_frame("R4 zero padding after unaligned data", 0, 32'h503, 10);
        wr_reg(3'd2, 32'h110);
        rd_reg(3'd4, v);
        chk("R7 acknowledge short frame", v, 0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        fill(32'h601, 61, 2);
        fill(32'h700, 70, 3);
        fill(32'h802, 5, 4);
        put_desc(32'h120, 32'h130, 32'h600, 1, 61, mkf(1, 1, 1, 61));
        put_desc(32'h130, 32'h140, 32'h700, 0, 70, mkf(1, 1, 1, 70));
        put_desc(32'h140, 0,       32'h800, 2, 5,  mkf(1, 1, 1, 5));
        clr_cap();
        wr_reg(3'd1, 32'h120);
        wait_cyc(1800);
        chk("R5 chain frame count", 32'(last_cnt), 3);
        check_frame("R5 chain frame 1", 0, 32'h601, 61);
        check_frame("R5 chain frame 2", 61, 32'h700, 70);
        check_frame("R4 chain frame 3 padded", 131, 32'h802, 5);
        chk("R5 mid-chain write-back has no end-of-queue", mem[32'h12C >> 2],
            mkf(1, 1, 0, 61));
        chk("R5 tail write-back has end-of-queue", mem[32'h14C >> 2],
            mkf(1, 1, 0, 5) | 32'h1000_0000);
        wr_reg(3'd2, 32'h120);
        rd_reg(3'd4, v);
        chk("R7 stale acknowledge keeps status", v, 1);
        wr_reg(3'd2, 32'h140);
        rd_reg(3'd4, v);
        chk("R7 latest acknowledge clears status", v, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        fill(32'h880, 8, 5);
        fill(32'h8C0, 8, 6);
        put_desc(32'h150, 32'h160, 32'h880, 0, 8, mkf(1, 1, 1, 8));
        put_desc(32'h160, 0,       32'h8C0, 0, 8, mkf(1, 1, 1, 8));
        clr_cap();
        wr_seen = 0;
        col_at = 2;
        col_addr = 32'h150;
        col_hit = 1'b0;
        col_arm = 1'b1;
        wr_reg(3'd1, 32'h150);
        wait_cyc(800);
        chk("R8 collision was provoked", 32'(col_hit), 1);
        rd_reg(3'd4, v);
        chk("R8 completion wins over same-cycle acknowledge", v, 1);
        wr_reg(3'd2, 32'h160);
        rd_reg(3'd4, v);
        chk("R8 later acknowledge clears", v, 0);
    endtask

    task automatic t_noown();
        logic [31:0] v;
        put_desc(32'h170, 0, 32'h900, 0, 20, mkf(1, 1, 0, 20));
        clr_cap();
        wr_reg(3'd1, 32'h170);
        wait_cyc(200);
        chk("R9 no bytes for unowned descriptor", 32'(cap_n), 0);
        rd_reg(3'd1, v);
        chk("R9 head cleared", v, 0);
        rd_reg(3'd4, v);
        chk("R9 no status raised", v, 0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        fill(32'h900, 20, 8);
        put_desc(32'h180, 0, 32'h900, 0, 20, mkf(0, 1, 1, 20));
        clr_cap();
        wr_reg(3'd1, 32'h180);
        wait_cyc(200);
        rd_reg(3'd4, v);
        chk("R10 sticky error set", v, 2);
        chk("R10 no bytes on error", 32'(cap_n), 0);
        mem[32'h18C >> 2] = mkf(1, 1, 1, 20);
        wait_cyc(100);
        chk("R10 no restart while error set", 32'(cap_n), 0);
        wr_reg(3'd4, 2);
        wait_cyc(400);
        check_frame("R10 resume after error clear", 0, 32'h900, 20);
        rd_reg(3'd4, v);
        chk("R10 error cleared and frame done", v, 1);
        wr_reg(3'd2, 32'h180);
    endtask

    task automatic t_td_idle();
        logic [31:0] v;
        wr_reg(3'd3, 1);
        wait_cyc(5);
        rd_reg(3'd2, v);
        chk("R11 teardown marker in completion register", v, MARK);
        rd_reg(3'd4, v);
        chk("R11 teardown raises status", v, 1);
        wr_reg(3'd2, MARK);
        rd_reg(3'd4, v);
        chk("R11 marker acknowledge clears status", v, 0);
    endtask

    task automatic t_td_busy();
        logic [31:0] v;
        fill(32'hA00, 40, 9);
        fill(32'hB00, 40, 10);
        put_desc(32'h1A0, 32'h1B0, 32'hA00, 0, 40, mkf(1, 1, 1, 40));
        put_desc(32'h1B0, 0,       32'hB00, 0, 40, mkf(1, 1, 1, 40));
        clr_cap();
        bp_on = 1'b1;
        wr_reg(3'd1, 32'h1A0);
        wait_cyc(30);
        wr_reg(3'd1, 32'h1B0);
        rd_reg(3'd1, v);
        chk("R12 head write ignored while busy", v, 32'h1A0);
        wr_reg(3'd3, 1);
        wait_cyc(800);
        bp_on = 1'b0;
        chk("R11 only the frame in flight is sent", 32'(last_cnt), 1);
        check_frame("R11 frame in flight completes intact", 0, 32'hA00, 40);
        chk("R11 next descriptor untouched", mem[32'h1BC >> 2], mkf(1, 1, 1, 40));
        rd_reg(3'd2, v);
        chk("R11 completion holds marker", v, MARK);
        rd_reg(3'd1, v);
        chk("R11 head cleared by teardown", v, 0);
        wr_reg(3'd2, MARK);
        rd_reg(3'd4, v);
        chk("R11 status cleared after marker acknowledge", v, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_enable();
        t_short_pad();
        t_chain();
        t_collide();
        t_noown();
        t_error();
        t_td_idle();
        t_td_busy();
        chk("R13 request held until acknowledge", 32'(hold_viol), 0);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule